// File: doc/BRIEF.md
# Standby refresh and address-space configuration register

This block keeps the low-power configuration of a pseudo-static memory array that is split into four equal sections, chosen by the two highest address bits. A sleep controller loads the register with a strobe and a five-bit address pattern. Bit 4 of the pattern must be set for the write to count. Bit 3 then chooses between two meanings of the same region code:
- With bit 3 clear, the code limits which sections are refreshed in standby.
- With bit 3 set, the code limits which sections can be addressed at all.

The region is picked by a two-bit size code (bits 1:0) and a direction bit (bit 2). The size code gives one quarter, one half, three quarters or all of the array. The direction bit counts the region up from address zero or down from the top address.

The block drives three outputs:
- A one-bit-per-section refresh mask, for the refresh engine.
- An in-range flag for the current access address, for the access path.
- A flag that shows when the address space is actually cut down.

Reset restores the full array: every section is refreshed and every address is usable.

Top module: `lpcfg_space_reg`

## Requirements
- R1: While reset is asserted, and after it is released until the first accepted write, `refresh_mask` is 4'b1111, `space_limited` is 0 and `access_ok` is 1 for every address.
- R2: A write is accepted on a rising clock edge at which `cfg_we` is 1 and `cfg_bits[4]` is 1. Its effect shows on the outputs right after that edge and not before.
- R3: A write with `cfg_bits[4]` = 0 is ignored. The outputs keep their previous values.
- R4: The size code `cfg_bits[1:0]` selects the region size: 2'b11 is one section, 2'b10 is two sections, 2'b01 is three sections and 2'b00 is all four sections.
- R5: With `cfg_bits[2]` = 0 the region holds the lowest sections, starting at section 0. With `cfg_bits[2]` = 1 it holds the highest sections, ending at section 3. `refresh_mask` bit i stands for section i, where i is `acc_addr[19:18]`.
- R6: With `cfg_bits[3]` = 0 (refresh-only mode), `refresh_mask` equals the selected region and `access_ok` is 1 for every address.
- R7: With `cfg_bits[3]` = 1 (reduced-space mode), `access_ok` is 1 only when section `acc_addr[19:18]` lies in the selected region. `refresh_mask` also equals that region.
- R8: `space_limited` is 1 exactly when reduced-space mode is held with a size code other than 2'b00.
- R9: The configuration stays in force over any number of cycles without an accepted write. Values on `cfg_bits` while `cfg_we` is 0 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low, loads the full-array state |
| cfg_we | input | 1 | Configuration write strobe from the sleep controller |
| cfg_bits | input | 5 | Address pattern of the configuration write (bit 4 enable, bit 3 mode, bit 2 direction, bits 1:0 size) |
| acc_addr | input | 20 | Word address of the current access |
| refresh_mask | output | 4 | Sections to refresh in standby, bit i for section i |
| access_ok | output | 1 | The access address lies inside the usable space |
| space_limited | output | 1 | Reduced-space mode is active with less than the full array |

## Verification
The configuration register is the only state in the block. A write accepted at a rising edge therefore appears on `refresh_mask` and `space_limited` right after that edge. `access_ok` is combinational from the held configuration and `acc_addr`, so it follows an address change in the same cycle. The bench drives every input on the falling edge and samples 1 ns later. A write's result is read half a cycle after the edge that captured it, and a new address is read in the cycle it is applied. One directed check reads the outputs while the strobe is high but before the capturing edge, to confirm that no result comes early.

// File: rtl/lpcfg_pkg.sv
package lpcfg_pkg;

    // Held configuration: mode, direction and size code
    typedef struct packed {
        logic       limit_space;   // 1: reduced address space, 0: refresh-only
        logic       from_top;      // 1: region ends at the highest section
        logic [1:0] size_code;     // 11 quarter, 10 half, 01 three quarters, 00 full
    } lpcfg_t;

    localparam lpcfg_t LPCFG_DEFAULT = '{limit_space: 1'b0, from_top: 1'b0, size_code: 2'b00};

    // Number of quarters covered by a size code
    function automatic int unsigned quarters_of(input logic [1:0] code);
        return (code == 2'b00) ? 4 : (4 - int'(code));
    endfunction

endpackage

// File: rtl/lpcfg_store.sv
module lpcfg_store
    import lpcfg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [4:0] wr_bits,
    output lpcfg_t     cfg_o
);

    lpcfg_t cfg_d;
    lpcfg_t cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en && wr_bits[4]) begin
            cfg_d.limit_space = wr_bits[3];
            cfg_d.from_top    = wr_bits[2];
            cfg_d.size_code   = wr_bits[1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= LPCFG_DEFAULT;
        else        cfg_q <= cfg_d;
    end

    assign cfg_o = cfg_q;

endmodule

// File: rtl/lpcfg_region_map.sv
module lpcfg_region_map
    import lpcfg_pkg::*;
#(
    parameter int unsigned SECTIONS = 4
) (
    input  lpcfg_t              cfg_i,
    output logic [SECTIONS-1:0] region_o
);

    localparam int unsigned PER_QUARTER = SECTIONS / 4;

    int unsigned sel_count;

    always_comb begin
        sel_count = PER_QUARTER * quarters_of(cfg_i.size_code);
    end

    for (genvar gi = 0; gi < SECTIONS; gi++) begin : g_sec
        always_comb begin
            if (cfg_i.from_top) region_o[gi] = (gi >= int'(SECTIONS - sel_count));
            else                region_o[gi] = (gi < int'(sel_count));
        end
    end

endmodule

// File: rtl/lpcfg_range_check.sv
module lpcfg_range_check #(
    parameter int unsigned ADDR_W   = 20,
    parameter int unsigned SECTIONS = 4
) (
    input  logic [ADDR_W-1:0]   addr_i,
    input  logic [SECTIONS-1:0] region_i,
    input  logic                limit_i,
    output logic                in_range_o
);

    localparam int unsigned SEC_W = $clog2(SECTIONS);

    logic [SEC_W-1:0] sec_idx;

    always_comb begin
        sec_idx    = addr_i[ADDR_W-1 -: SEC_W];
        in_range_o = !limit_i || region_i[sec_idx];
    end

endmodule

// File: rtl/lpcfg_space_reg.sv
module lpcfg_space_reg
    import lpcfg_pkg::*;
#(
    parameter int unsigned ADDR_W   = 20,
    parameter int unsigned SECTIONS = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we,
    input  logic [4:0]          cfg_bits,
    input  logic [ADDR_W-1:0]   acc_addr,
    output logic [SECTIONS-1:0] refresh_mask,
    output logic                access_ok,
    output logic                space_limited
);

    lpcfg_t              cfg;
    logic [SECTIONS-1:0] region;

    lpcfg_store u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_we),
        .wr_bits (cfg_bits),
        .cfg_o   (cfg)
    );

    lpcfg_region_map #(.SECTIONS(SECTIONS)) u_map (
        .cfg_i    (cfg),
        .region_o (region)
    );

    lpcfg_range_check #(.ADDR_W(ADDR_W), .SECTIONS(SECTIONS)) u_range (
        .addr_i     (acc_addr),
        .region_i   (region),
        .limit_i    (cfg.limit_space),
        .in_range_o (access_ok)
    );

    assign refresh_mask  = region;
    assign space_limited = cfg.limit_space && (cfg.size_code != 2'b00);

endmodule

// File: rtl/lpcfg_space_reg_chk.sv
module lpcfg_space_reg_chk #(
    parameter int unsigned ADDR_W   = 20,
    parameter int unsigned SECTIONS = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic                cfg_we,
    input logic [4:0]          cfg_bits,
    input logic [ADDR_W-1:0]   acc_addr,
    input logic [SECTIONS-1:0] refresh_mask,
    input logic                access_ok,
    input logic                space_limited
);

    localparam int unsigned SEC_W = $clog2(SECTIONS);

    // R1: reset forces the full array
    a_r1_reset_full: assert property (@(posedge clk)
        !rst_n |=> (refresh_mask == '1) && !space_limited);

    // R2: a one-quarter write leaves exactly a quarter of the sections
    a_r2_quarter_write: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we && cfg_bits[4] && (cfg_bits[1:0] == 2'b11)
        |=> ($countones(refresh_mask) == SECTIONS / 4));

    // R3: ignored write
    a_r3_ignore_write: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we && !cfg_bits[4] |=> $stable(refresh_mask) && $stable(space_limited));

    // R9: state holds without a write
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> $stable(refresh_mask) && $stable(space_limited));

    // R4: the region is never empty
    a_r4_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(refresh_mask) >= 1);

    // R6: without a limited space every access is allowed
    a_r6_open_space: assert property (@(posedge clk) disable iff (!rst_n)
        !space_limited |-> access_ok);

    // R7: an allowed access in a limited space targets a kept section
    a_r7_in_region: assert property (@(posedge clk) disable iff (!rst_n)
        space_limited && access_ok |-> refresh_mask[acc_addr[ADDR_W-1 -: SEC_W]]);

endmodule

bind lpcfg_space_reg lpcfg_space_reg_chk #(.ADDR_W(ADDR_W), .SECTIONS(SECTIONS)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_we        (cfg_we),
    .cfg_bits      (cfg_bits),
    .acc_addr      (acc_addr),
    .refresh_mask  (refresh_mask),
    .access_ok     (access_ok),
    .space_limited (space_limited)
);

// File: tb/lpcfg_space_reg_tb.sv
module lpcfg_space_reg_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [4:0]  cfg_bits = '0;
    logic [19:0] acc_addr = '0;
    logic [3:0]  refresh_mask;
    logic        access_ok;
    logic        space_limited;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    lpcfg_space_reg u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_we        (cfg_we),
        .cfg_bits      (cfg_bits),
        .acc_addr      (acc_addr),
        .refresh_mask  (refresh_mask),
        .access_ok     (access_ok),
        .space_limited (space_limited)
    );

    // {cfg_bits[4:0], section[1:0], mask[3:0], access_ok, space_limited}
    localparam int NV = 18;
    localparam logic [12:0] VEC [NV] = '{
        {5'b10011, 2'd3, 4'b0001, 1'b1, 1'b0},
        {5'b10010, 2'd2, 4'b0011, 1'b1, 1'b0},
        {5'b10001, 2'd3, 4'b0111, 1'b1, 1'b0},
        {5'b10111, 2'd0, 4'b1000, 1'b1, 1'b0},
        {5'b10110, 2'd1, 4'b1100, 1'b1, 1'b0},
        {5'b10101, 2'd0, 4'b1110, 1'b1, 1'b0},
        {5'b10000, 2'd2, 4'b1111, 1'b1, 1'b0},
        {5'b11011, 2'd0, 4'b0001, 1'b1, 1'b1},
        {5'b11011, 2'd1, 4'b0001, 1'b0, 1'b1},
        {5'b11010, 2'd1, 4'b0011, 1'b1, 1'b1},
        {5'b11001, 2'd3, 4'b0111, 1'b0, 1'b1},
        {5'b11001, 2'd2, 4'b0111, 1'b1, 1'b1},
        {5'b11111, 2'd3, 4'b1000, 1'b1, 1'b1},
        {5'b11110, 2'd1, 4'b1100, 1'b0, 1'b1},
        {5'b11101, 2'd0, 4'b1110, 1'b0, 1'b1},
        {5'b11101, 2'd1, 4'b1110, 1'b1, 1'b1},
        {5'b11000, 2'd3, 4'b1111, 1'b1, 1'b0},
        {5'b11100, 2'd0, 4'b1111, 1'b1, 1'b0}
    };

    task automatic check(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic do_write(input logic [4:0] bits);
        @(negedge clk);
        cfg_we   = 1'b1;
        cfg_bits = bits;
        @(negedge clk);
        cfg_we   = 1'b0;
    endtask

    task automatic set_sec(input logic [1:0] sec);
        acc_addr = {sec, 18'h2A5C3};
        #1;
    endtask

    initial begin
        #100000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 mask in reset", int'(refresh_mask), 4'hF);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 mask", int'(refresh_mask), 4'hF);
        check("R1 limited", int'(space_limited), 0);
        for (int s = 0; s < 4; s++) begin
            set_sec(2'(s));
            check("R1 access", int'(access_ok), 1);
        end

        // Vector table
        for (int v = 0; v < NV; v++) begin
            do_write(VEC[v][12:8]);
            set_sec(VEC[v][7:6]);
            check("R4 R5 mask", int'(refresh_mask), int'(VEC[v][5:2]));
            check(VEC[v][11] ? "R7 access" : "R6 access", int'(access_ok), int'(VEC[v][1]));
            check("R8 limited", int'(space_limited), int'(VEC[v][0]));
        end

        // R2: no effect before the capturing edge
        do_write(5'b11111);
        @(negedge clk);
        cfg_we   = 1'b1;
        cfg_bits = 5'b10011;
        #1;
        check("R2 before edge", int'(refresh_mask), 4'h8);
        @(posedge clk);
        #1;
        check("R2 after edge", int'(refresh_mask), 4'h1);
        check("R2 limited", int'(space_limited), 0);
        @(negedge clk);
        cfg_we = 1'b0;

        // R3: write with bit 4 clear is ignored
        do_write(5'b11111);
        do_write(5'b01011);
        set_sec(2'd0);
        check("R3 mask", int'(refresh_mask), 4'h8);
        check("R3 limited", int'(space_limited), 1);
        check("R3 access", int'(access_ok), 0);

        // R9: held over idle cycles, cfg_bits ignored without strobe
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            cfg_bits = 5'(5'b10000 + k);
        end
        set_sec(2'd1);
        check("R9 mask", int'(refresh_mask), 4'h8);
        check("R9 access", int'(access_ok), 0);
        set_sec(2'd3);
        check("R9 access top", int'(access_ok), 1);
        check("R9 limited", int'(space_limited), 1);

        // R1: mid-run reset restores the full array
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R1 reset mask", int'(refresh_mask), 4'hF);
        check("R1 reset limited", int'(space_limited), 0);
        set_sec(2'd0);
        check("R1 reset access", int'(access_ok), 1);
        @(negedge clk);
        rst_n = 1'b1;

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule